// File: doc/BRIEF.md
# Prioritized Interrupt Level Concentrator

This block gathers thirteen level-sensitive interrupt request lines from board peripherals and presents them to a host processor as a single 4-bit encoded interrupt level. Every source has a fixed priority rank (0 is the most urgent, 12 the least) and, separately, a fixed bit position in a 16-bit status view and a 16-bit enable mask. The rank and the bit position do not follow each other. Among the sources that are both requesting and enabled, the block selects the lowest rank. It drives that rank XOR 15 on a registered output, so that an idle state reads as 0.

A small register window of 64 byte offsets sits on a simple synchronous bus. The bus has a one-cycle write strobe and a combinational read path. The window holds the enable mask, a power-control register, a general output register and a constant version word. The power-control and general output registers also drive output pins.

Top module: `irl_concentrator`

## Requirements
- R1: After a synchronous reset, the mask, power-control and general output registers are 0, and `irl_o` is 0.
- R2: The request inputs are indexed by rank. Request rank r occupies one status/mask bit: ranks 0..12 map to bits 11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15 respectively. Bits 1, 2 and 3 belong to no source.
- R3: A request counts as pending only while its input is high and its mask bit is 1. A masked request has no effect on `irl_o`.
- R4: `irl_o` equals 15 minus the lowest pending rank, which is rank XOR 15. When nothing is pending, `irl_o` is 0.
- R5: `irl_o` is a register. It reflects the request inputs and the mask as they stand at each rising clock edge.
- R6: A mask write takes effect on `irl_o` at the same clock edge that stores it, with no source having to change.
- R7: Byte offset 0x00 is the mask register. All 16 bits are written and read back.
- R8: Byte offset 0x30 is the power-control register. It is read/write, and its value drives `pwr_ctl_o`.
- R9: Byte offset 0x36 is the general output register. It is read/write, and its value drives `gp_out_o`.
- R10: Byte offset 0x32 always reads 0x0010. Writes to it change nothing.
- R11: Every other offset in 0x00..0x3F, odd offsets included, reads as 0. Writes to those offsets change no register and do not change `irl_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 13 | Interrupt request levels, bit r is the source of rank r |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_addr | input | 6 | Byte offset into the register window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| irl_o | output | 4 | Encoded interrupt level, lowest pending rank XOR 15 |
| pwr_ctl_o | output | 16 | Power-control register contents |
| gp_out_o | output | 16 | General output register contents |

## Verification
The hardest case to reach from the ports is a mask write that changes the winner while every request line holds still. The stimulus first raises all thirteen requests with the mask cleared. It then writes a mask in which only one bit is set and samples `irl_o` immediately after the storing edge. The scrambled rank-to-bit table is covered by sweeping all 8192 request patterns under a full mask. It is also covered by enabling, and separately disabling, each source's bit on its own.

// File: rtl/irl_pkg.sv
package irl_pkg;
  localparam int NUM_SRC = 13;
  localparam int REG_W   = 16;
  localparam int LVL_W   = 4;
  localparam int ADDR_W  = 6;

  // Rank to status/mask bit position (independent of priority order)
  function automatic int src_bit(input int rank);
    case (rank)
      0:  return 11;
      1:  return 9;
      2:  return 8;
      3:  return 12;
      4:  return 10;
      5:  return 6;
      6:  return 5;
      7:  return 4;
      8:  return 7;
      9:  return 14;
      10: return 13;
      11: return 0;
      12: return 15;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/irl_src_map.sv
module irl_src_map
  import irl_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  parameter int W     = REG_W
) (
  input  logic [N_SRC-1:0] req_i,
  input  logic [W-1:0]     mask_i,
  output logic [W-1:0]     mon_o,
  output logic [N_SRC-1:0] pend_o
);
  logic [W-1:0] mon_bits [N_SRC];

  for (genvar r = 0; r < N_SRC; r++) begin : g_src
    localparam int BP = src_bit(r);
    assign mon_bits[r] = W'(req_i[r]) << BP;
    assign pend_o[r]   = req_i[r] & mask_i[BP];
  end

  always_comb begin
    mon_o = '0;
    for (int r = 0; r < N_SRC; r++) mon_o = mon_o | mon_bits[r];
  end
endmodule

// File: rtl/irl_prio_enc.sv
module irl_prio_enc #(
  parameter int N_SRC = 13,
  parameter int LW    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] pend_i,
  output logic [LW-1:0]    irl_o
);
  localparam logic [LW-1:0] IDLE_LVL = '1;

  logic [LW-1:0] lvl;
  logic [LW-1:0] irl_q;

  always_comb begin
    lvl = IDLE_LVL;
    for (int r = N_SRC - 1; r >= 0; r--) begin
      if (pend_i[r]) lvl = LW'(r);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irl_q <= '0;
    else     irl_q <= lvl ^ IDLE_LVL;
  end

  assign irl_o = irl_q;
endmodule

// File: rtl/irl_regfile.sv
module irl_regfile #(
  parameter int              AW       = 6,
  parameter int              W        = 16,
  parameter logic [AW-1:0]   OFS_MASK = 6'h00,
  parameter logic [AW-1:0]   OFS_PWR  = 6'h30,
  parameter logic [AW-1:0]   OFS_VER  = 6'h32,
  parameter logic [AW-1:0]   OFS_GPO  = 6'h36,
  parameter logic [W-1:0]    VERSION  = 16'h0010
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  output logic [W-1:0]  mask_q_o,
  output logic [W-1:0]  mask_nxt_o,
  output logic [W-1:0]  pwr_o,
  output logic [W-1:0]  gpo_o
);
  logic [W-1:0] mask_q, pwr_q, gpo_q;
  logic         hit_mask, hit_pwr, hit_gpo, hit_ver;

  assign hit_mask = (addr_i == OFS_MASK);
  assign hit_pwr  = (addr_i == OFS_PWR);
  assign hit_gpo  = (addr_i == OFS_GPO);
  assign hit_ver  = (addr_i == OFS_VER);

  assign mask_nxt_o = (we_i && hit_mask) ? wdata_i : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      pwr_q  <= '0;
      gpo_q  <= '0;
    end else begin
      mask_q <= mask_nxt_o;
      if (we_i && hit_pwr) pwr_q <= wdata_i;
      if (we_i && hit_gpo) gpo_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_mask)     rdata_o = mask_q;
    else if (hit_pwr) rdata_o = pwr_q;
    else if (hit_gpo) rdata_o = gpo_q;
    else if (hit_ver) rdata_o = VERSION;
  end

  assign mask_q_o = mask_q;
  assign pwr_o    = pwr_q;
  assign gpo_o    = gpo_q;
endmodule

// File: rtl/irl_concentrator.sv
module irl_concentrator
  import irl_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  parameter int W     = REG_W,
  parameter int AW    = ADDR_W,
  parameter int LW    = LVL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] req_i,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [W-1:0]     bus_wdata,
  output logic [W-1:0]     bus_rdata,
  output logic [LW-1:0]    irl_o,
  output logic [W-1:0]     pwr_ctl_o,
  output logic [W-1:0]     gp_out_o
);
  logic [W-1:0]     mask_q, mask_nxt, mon;
  logic [N_SRC-1:0] pend;

  irl_regfile #(.AW(AW), .W(W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .we_i       (bus_we),
    .addr_i     (bus_addr),
    .wdata_i    (bus_wdata),
    .rdata_o    (bus_rdata),
    .mask_q_o   (mask_q),
    .mask_nxt_o (mask_nxt),
    .pwr_o      (pwr_ctl_o),
    .gpo_o      (gp_out_o)
  );

  // The mask about to be stored is used so a write acts at its own edge
  irl_src_map #(.N_SRC(N_SRC), .W(W)) u_map (
    .req_i  (req_i),
    .mask_i (mask_nxt),
    .mon_o  (mon),
    .pend_o (pend)
  );

  irl_prio_enc #(.N_SRC(N_SRC), .LW(LW)) u_enc (
    .clk    (clk),
    .rst    (rst),
    .pend_i (pend),
    .irl_o  (irl_o)
  );
endmodule

// File: rtl/irl_concentrator_chk.sv
module irl_concentrator_chk (
  input logic        clk,
  input logic        rst,
  input logic [12:0] req_i,
  input logic        bus_we,
  input logic [5:0]  bus_addr,
  input logic [15:0] bus_wdata,
  input logic [15:0] bus_rdata,
  input logic [3:0]  irl_o,
  input logic [15:0] pwr_ctl_o,
  input logic [15:0] mask_q,
  input logic [15:0] mon
);
  logic mask_wr;
  assign mask_wr = bus_we && (bus_addr == 6'h00);

  p_idle_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (req_i == '0) |=> (irl_o == 4'h0));

  p_top_rank_r4: assert property (@(posedge clk) disable iff (rst)
    (req_i[0] && mask_q[11] && !mask_wr) |=> (irl_o == 4'hF));

  p_masked_r3: assert property (@(posedge clk) disable iff (rst)
    ((mask_q == '0) && !mask_wr) |=> (irl_o == 4'h0));

  p_mask_now_r6: assert property (@(posedge clk) disable iff (rst)
    (mask_wr && bus_wdata[11] && req_i[0]) |=> (irl_o == 4'hF));

  p_version_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == 6'h32) |-> (bus_rdata == 16'h0010));

  p_unmapped_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_addr != 6'h00 && bus_addr != 6'h30 && bus_addr != 6'h32 &&
     bus_addr != 6'h36) |-> (bus_rdata == 16'h0000));

  p_pwr_wr_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 6'h30) |=> (pwr_ctl_o == $past(bus_wdata)));

  p_unused_bits_r2: assert property (@(posedge clk) disable iff (rst)
    (mon[3:1] == 3'b000));
endmodule

bind irl_concentrator irl_concentrator_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_i     (req_i),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irl_o     (irl_o),
  .pwr_ctl_o (pwr_ctl_o),
  .mask_q    (mask_q),
  .mon       (mon)
);

// File: tb/tb_irl_concentrator.sv
module tb_irl_concentrator;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] req_i = '0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  irl_o;
  logic [15:0] pwr_ctl_o, gp_out_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irl_concentrator dut (
    .clk(clk), .rst(rst), .req_i(req_i), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irl_o(irl_o), .pwr_ctl_o(pwr_ctl_o), .gp_out_o(gp_out_o)
  );

  function automatic int bitpos(input int r);
    case (r)
      0: return 11;  1: return 9;   2: return 8;   3: return 12;
      4: return 10;  5: return 6;   6: return 5;   7: return 4;
      8: return 7;   9: return 14;  10: return 13; 11: return 0;
      default: return 15;
    endcase
  endfunction

  function automatic logic [3:0] exp_irl(input logic [12:0] rq, input logic [15:0] mk);
    for (int r = 0; r < 13; r++)
      if (rq[r] && mk[bitpos(r)]) return 4'(15 - r);
    return 4'h0;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic set_req(input logic [12:0] v);
    @(negedge clk);
    req_i = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [15:0] mk;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irl", 16'(irl_o), 16'h0);
    chk("R1 pwr pin", pwr_ctl_o, 16'h0);
    chk("R1 gpo pin", gp_out_o, 16'h0);
    rd(6'h00, d); chk("R1 mask", d, 16'h0);
    rd(6'h30, d); chk("R1 pwr", d, 16'h0);
    rd(6'h36, d); chk("R1 gpo", d, 16'h0);

    // R3 all requests but everything masked
    set_req('1);
    chk("R3 all masked", 16'(irl_o), 16'h0);

    // R6 mask write acts at its storing edge with requests held
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 6'h00; bus_wdata = 16'h0200;
    @(negedge clk);
    bus_we = 1'b0;
    chk("R6 mask rank1 now", 16'(irl_o), 16'd14);
    @(negedge clk);
    bus_we = 1'b1; bus_wdata = 16'h8000;
    @(negedge clk);
    bus_we = 1'b0;
    chk("R6 mask rank12 now", 16'(irl_o), 16'd3);

    // R7 mask read back
    wr(6'h00, 16'hA5C3); rd(6'h00, d); chk("R7 mask rb", d, 16'hA5C3);
    wr(6'h00, 16'h5A3C); rd(6'h00, d); chk("R7 mask rb2", d, 16'h5A3C);

    // R2/R4/R5 exhaustive request sweep under full mask
    wr(6'h00, 16'hFFFF);
    for (int p = 0; p < 8192; p++) begin
      set_req(13'(p));
      chk("R4 sweep", 16'(irl_o), 16'(exp_irl(13'(p), 16'hFFFF)));
    end

    // R2/R3 per-source bit enable and disable
    for (int r = 0; r < 13; r++) begin
      wr(6'h00, 16'(1) << bitpos(r));
      set_req('1);
      chk("R2 only own bit", 16'(irl_o), 16'(15 - r));
      wr(6'h00, ~(16'(1) << bitpos(r)));
      set_req(13'(1) << r);
      chk("R3 own bit off", 16'(irl_o), 16'h0);
    end

    // R4/R5 mixed mask and request patterns
    mk = 16'hACE1;
    for (int k = 0; k < 200; k++) begin
      logic [12:0] rq;
      mk = {mk[14:0], mk[15] ^ mk[13] ^ mk[12] ^ mk[10]};
      rq = 13'(mk * 16'd7 + 16'(k));
      wr(6'h00, mk);
      set_req(rq);
      chk("R5 mixed", 16'(irl_o), 16'(exp_irl(rq, mk)));
    end

    // R8/R9 registers and pins
    wr(6'h30, 16'h1357); rd(6'h30, d);
    chk("R8 pwr rb", d, 16'h1357); chk("R8 pwr pin", pwr_ctl_o, 16'h1357);
    wr(6'h36, 16'hFEDC); rd(6'h36, d);
    chk("R9 gpo rb", d, 16'hFEDC); chk("R9 gpo pin", gp_out_o, 16'hFEDC);

    // R10 version is constant
    rd(6'h32, d); chk("R10 ver", d, 16'h0010);
    wr(6'h32, 16'hFFFF); rd(6'h32, d); chk("R10 ver after wr", d, 16'h0010);

    // R11 unmapped offsets: reads 0, writes inert
    wr(6'h00, 16'h0000);
    set_req('1);
    for (int a = 0; a < 64; a++) begin
      if (a != 'h00 && a != 'h30 && a != 'h32 && a != 'h36) begin
        wr(6'(a), 16'hFFFF);
        rd(6'(a), d);
        chk("R11 unmapped rd", d, 16'h0);
      end
    end
    chk("R11 irl untouched", 16'(irl_o), 16'h0);
    rd(6'h00, d); chk("R11 mask kept", d, 16'h0000);
    rd(6'h30, d); chk("R11 pwr kept", d, 16'h1357);
    rd(6'h36, d); chk("R11 gpo kept", d, 16'hFEDC);

    // R1 reset again clears everything
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd(6'h30, d); chk("R1 pwr after rst", d, 16'h0);
    chk("R1 irl after rst", 16'(irl_o), 16'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule